// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a 32-bit linear address into a 32-bit physical address by walking a two-level page table held in memory. A walk begins on a start strobe. The block first reads a directory entry. The directory is located by a base register, and the entry is chosen by the top ten bits of the linear address. The frame held in that entry locates the second-level table. The middle ten bits of the linear address then choose an entry in that table. The final address is the frame from the table entry joined to the low twelve offset bits.

Both reads go through a single request/acknowledge memory port. The request holds until the acknowledge arrives, so memory latency can be anything. Each entry carries a present flag in bit 0. A clear flag ends the walk at once with a fault. When translation is disabled, the block passes the linear address straight through one cycle after the strobe.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `fault_o` and `mem_req_o` are low and `phys_addr_o` is zero until a walk or bypass completes.
- R2: When start is accepted with `paging_en_i` high, `mem_req_o` rises in the next cycle. The address is {`dir_base_i`[31:12], linear[31:22], 2'b00}, using the values sampled with start.
- R3: When the directory read is acknowledged and bit 0 of the returned entry is 1, the next request has the address {entry[31:12], linear[21:12], 2'b00}.
- R4: While `mem_req_o` is high and `mem_ack_i` is low, the request stays high and `mem_addr_o` stays unchanged in the next cycle.
- R5: When the table read is acknowledged with bit 0 set, `done_o` is high in the next cycle with `fault_o` low. `phys_addr_o` is then {entry[31:12], linear[11:0]}.
- R6: A directory entry with bit 0 clear ends the walk. In the next cycle `done_o` and `fault_o` are high and `phys_addr_o` is zero, and no table read is issued.
- R7: A table entry with bit 0 clear ends the walk. In the next cycle `done_o` and `fault_o` are high and `phys_addr_o` is zero.
- R8: When start is accepted with `paging_en_i` low, `done_o` is high in the next cycle. In that cycle `fault_o` is low and `phys_addr_o` equals the sampled linear address, and no memory request is made.
- R9: A start strobe that arrives while a walk or its completion cycle is in progress is ignored. The running walk finishes with its original address.
- R10: `done_o` lasts exactly one cycle per walk. `fault_o` is high only together with `done_o`. `phys_addr_o` holds its last value between walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a translation (accepted only when idle) |
| paging_en_i | input | 1 | 1 = walk the tables, 0 = pass the address through |
| lin_addr_i | input | 32 | Linear address to translate |
| dir_base_i | input | 32 | Directory base; bits 31:12 give its frame |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata_i | input | 32 | Entry returned by memory |
| phys_addr_o | output | 32 | Translated address, valid when done and not faulted |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk stopped on a non-present entry |

## Verification
The hardest case to reach from the ports is a start strobe that lands in the middle of a walk that is blocked on the memory acknowledge. It takes a slow memory and a second strobe with a different address and base. The bench's memory model holds the acknowledge back for a programmable number of cycles and pulses a second start while the directory read is still pending. It then confirms that the first address is the one translated. The two fault exits are reached by leaving chosen directory and table slots unpopulated. The maximum directory and table indices are covered by the all-ones linear address.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_RD_TBL,
    ST_DONE,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        paging_en_i,
  input  logic        ack_i,
  input  logic        present_i,
  output walk_state_e state_o,
  output logic        take_walk_o,
  output logic        take_bypass_o,
  output logic        dir_hit_o,
  output logic        tbl_hit_o,
  output logic        fault_set_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d       = state_q;
    take_walk_o   = 1'b0;
    take_bypass_o = 1'b0;
    dir_hit_o     = 1'b0;
    tbl_hit_o     = 1'b0;
    fault_set_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (paging_en_i) begin
          take_walk_o = 1'b1;
          state_d     = ST_RD_DIR;
        end else begin
          take_bypass_o = 1'b1;
          state_d       = ST_DONE;
        end
      end
      ST_RD_DIR: if (ack_i) begin
        if (present_i) begin
          dir_hit_o = 1'b1;
          state_d   = ST_RD_TBL;
        end else begin
          fault_set_o = 1'b1;
          state_d     = ST_FAULT;
        end
      end
      ST_RD_TBL: if (ack_i) begin
        if (present_i) begin
          tbl_hit_o = 1'b1;
          state_d   = ST_DONE;
        end else begin
          fault_set_o = 1'b1;
          state_d     = ST_FAULT;
        end
      end
      ST_DONE, ST_FAULT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned FRAME_W    = 20,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned ENTRY_LOG2 = 2,
  localparam int unsigned ADDR_W    = FRAME_W + IDX_W + ENTRY_LOG2
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   idx_hi_i,
  input  logic [IDX_W-1:0]   idx_lo_i,
  input  logic               sel_hi_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [IDX_W-1:0] idx;
  assign idx = sel_hi_i ? idx_hi_i : idx_lo_i;

  generate
    if (ENTRY_LOG2 == 0) begin : g_byte_entry
      assign addr_o = {frame_i, idx};
    end else begin : g_wide_entry
      assign addr_o = {frame_i, idx, {ENTRY_LOG2{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  entry_i,
  output logic               present_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic unused_attr;
  assign present_o   = entry_i[0];
  assign frame_o     = entry_i[ADDR_W-1:OFF_W];
  assign unused_attr = ^entry_i[OFF_W-1:1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned ENTRY_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              paging_en_i,
  input  logic [ADDR_W-1:0] lin_addr_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic              done_o,
  output logic              fault_o
);
  localparam int unsigned FRAME_W  = ADDR_W - OFF_W;
  localparam int unsigned TBL_LSB  = OFF_W;
  localparam int unsigned DIR_LSB  = OFF_W + IDX_W;

  walk_state_e        state;
  logic               take_walk, take_bypass, dir_hit, tbl_hit, fault_set;
  logic               present;
  logic [FRAME_W-1:0] entry_frame;
  logic [ADDR_W-1:0]  lin_q, phys_q;
  logic [FRAME_W-1:0] frame_q;
  logic               walk_busy;
  logic               in_dir_rd;

  pt_walk_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .paging_en_i   (paging_en_i),
    .ack_i         (mem_ack_i),
    .present_i     (present),
    .state_o       (state),
    .take_walk_o   (take_walk),
    .take_bypass_o (take_bypass),
    .dir_hit_o     (dir_hit),
    .tbl_hit_o     (tbl_hit),
    .fault_set_o   (fault_set)
  );

  pt_entry_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_dec (
    .entry_i   (mem_rdata_i),
    .present_o (present),
    .frame_o   (entry_frame)
  );

  pt_entry_addr #(.FRAME_W(FRAME_W), .IDX_W(IDX_W), .ENTRY_LOG2(ENTRY_LOG2)) i_eaddr (
    .frame_i  (frame_q),
    .idx_hi_i (lin_q[DIR_LSB +: IDX_W]),
    .idx_lo_i (lin_q[TBL_LSB +: IDX_W]),
    .sel_hi_i (in_dir_rd),
    .addr_o   (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_q   <= '0;
      frame_q <= '0;
      phys_q  <= '0;
    end else begin
      if (take_walk) begin
        lin_q   <= lin_addr_i;
        frame_q <= dir_base_i[ADDR_W-1:OFF_W];
      end
      if (dir_hit)     frame_q <= entry_frame;
      if (take_bypass) phys_q  <= lin_addr_i;
      if (tbl_hit)     phys_q  <= {entry_frame, lin_q[OFF_W-1:0]};
      if (fault_set)   phys_q  <= '0;
    end
  end

  assign in_dir_rd   = (state == ST_RD_DIR);
  assign walk_busy   = (state != ST_IDLE);
  assign mem_req_o   = (state == ST_RD_DIR) || (state == ST_RD_TBL);
  assign done_o      = (state == ST_DONE) || (state == ST_FAULT);
  assign fault_o     = (state == ST_FAULT);
  assign phys_addr_o = phys_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned ENTRY_LOG2 = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              paging_en_i,
  input logic [ADDR_W-1:0] lin_addr_i,
  input logic [ADDR_W-1:0] dir_base_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_rdata_i,
  input logic [ADDR_W-1:0] phys_addr_o,
  input logic              done_o,
  input logic              fault_o,
  input logic              walk_busy,
  input logic              in_dir_rd,
  input logic [ADDR_W-1:0] lin_q
);
  localparam int unsigned DIR_LSB = OFF_W + IDX_W;

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  assert_dir_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !walk_busy && start_i && paging_en_i |=> mem_req_o &&
      mem_addr_o == {$past(dir_base_i[ADDR_W-1:OFF_W]), $past(lin_addr_i[DIR_LSB +: IDX_W]),
                     {ENTRY_LOG2{1'b0}}});

  assert_tbl_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_dir_rd && mem_ack_i && mem_rdata_i[0] |=> mem_req_o &&
      mem_addr_o == {$past(mem_rdata_i[ADDR_W-1:OFF_W]), lin_q[OFF_W +: IDX_W],
                     {ENTRY_LOG2{1'b0}}});

  assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !walk_busy && start_i && !paging_en_i |=> done_o && !fault_o && !mem_req_o &&
      phys_addr_o == $past(lin_addr_i));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fault_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);

  assert_fault_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> phys_addr_o == '0);

  assert_dir_fault_no_tbl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_dir_rd && mem_ack_i && !mem_rdata_i[0] |=> fault_o && !mem_req_o);
endmodule

bind pt_walker pt_walker_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_LOG2(ENTRY_LOG2)
) i_pt_walker_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .paging_en_i (paging_en_i),
  .lin_addr_i  (lin_addr_i),
  .dir_base_i  (dir_base_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .mem_rdata_i (mem_rdata_i),
  .phys_addr_o (phys_addr_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .walk_busy   (walk_busy),
  .in_dir_rd   (in_dir_rd),
  .lin_q       (lin_q)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        paging_en_i = 1'b1;
  logic [31:0] lin_addr_i = '0;
  logic [31:0] dir_base_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] phys_addr_o;
  logic        done_o;
  logic        fault_o;

  pt_walker i_pt_walker (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory model
  logic [31:0] mem [logic [31:0]];
  int lat = 0;
  int wait_cnt = 0;
  always @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (mem_req_o) begin
      if (wait_cnt >= lat) begin
        mem_ack_i   = 1'b1;
        mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
      end else begin
        wait_cnt++;
      end
    end
  end

  // behavioural reference: 0 idle, 1 dir read, 2 table read, 3 done, 4 fault
  int          m_ph = 0;
  logic [31:0] m_lin = '0, m_frame = '0, m_phys = '0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_phys = '0;
    end else begin
      case (m_ph)
        0: if (start_i) begin
          if (paging_en_i) begin
            m_lin = lin_addr_i; m_frame = dir_base_i >> 12; m_ph = 1;
          end else begin
            m_phys = lin_addr_i; m_ph = 3;
          end
        end
        1: if (mem_ack_i) begin
          if (mem_rdata_i[0]) begin m_frame = mem_rdata_i >> 12; m_ph = 2; end
          else begin m_phys = '0; m_ph = 4; end
        end
        2: if (mem_ack_i) begin
          if (mem_rdata_i[0]) begin m_phys = {mem_rdata_i[31:12], m_lin[11:0]}; m_ph = 3; end
          else begin m_phys = '0; m_ph = 4; end
        end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic        e_req;
      logic [31:0] e_addr;
      e_req = (m_ph == 1) || (m_ph == 2);
      check(mem_req_o == e_req, "R4 request", {31'b0, mem_req_o}, {31'b0, e_req});
      if (m_ph == 1) begin
        e_addr = {m_frame[19:0], m_lin[31:22], 2'b00};
        check(mem_addr_o == e_addr, "R2 directory address", mem_addr_o, e_addr);
      end
      if (m_ph == 2) begin
        e_addr = {m_frame[19:0], m_lin[21:12], 2'b00};
        check(mem_addr_o == e_addr, "R3 table address", mem_addr_o, e_addr);
      end
      check(done_o == (m_ph >= 3), "R10 done", {31'b0, done_o}, {31'b0, (m_ph >= 3)});
      check(fault_o == (m_ph == 4), "R6 fault", {31'b0, fault_o}, {31'b0, (m_ph == 4)});
      check(phys_addr_o == m_phys, "R5 physical address", phys_addr_o, m_phys);
    end
  end

  logic [31:0] r_phys;
  logic        r_fault;
  int          r_reqs;

  task automatic run(input logic [31:0] lin, input logic [31:0] base, input bit en);
    @(negedge clk_i);
    lin_addr_i = lin; dir_base_i = base; paging_en_i = en; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    r_reqs = 0;
    for (int i = 0; i < 200 && !done_o; i++) begin
      if (mem_req_o) r_reqs++;
      @(negedge clk_i);
    end
    r_phys = phys_addr_o; r_fault = fault_o;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
    finish_run();
  end

  localparam logic [31:0] BASE = 32'h0001_0000;

  initial begin
    // directory: slot 1 -> table at 0x20000, slot 0x3FF -> table at 0x30000, slot 0 absent
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0001_0FFC] = 32'h0003_0003;
    mem[32'h0002_000C] = 32'h1234_5001;
    mem[32'h0003_0FFC] = 32'hFFFF_F001;
    mem[32'h0002_0014] = 32'hABCD_E000; // table slot 5: not present

    repeat (3) @(negedge clk_i);
    check(!done_o && !fault_o && !mem_req_o, "R1 reset outputs", {29'b0, done_o, fault_o, mem_req_o}, 32'h0);
    check(phys_addr_o == 32'h0, "R1 reset phys", phys_addr_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!done_o && !mem_req_o && phys_addr_o == 0, "R1 after release", phys_addr_o, 32'h0);

    for (int l = 0; l < 3; l++) begin
      lat = (l == 0) ? 0 : (l == 1) ? 2 : 5;
      run(32'h0040_3ABC, BASE, 1'b1);
      check(r_phys == 32'h1234_5ABC && !r_fault, "R5 walk result", r_phys, 32'h1234_5ABC);
      check(r_reqs >= 2, "R3 two reads", r_reqs, 2);
      run(32'hFFFF_FFFF, BASE, 1'b1);
      check(r_phys == 32'hFFFF_FFFF && !r_fault, "R5 top indices", r_phys, 32'hFFFF_FFFF);
      run(32'h0000_0000, BASE, 1'b1);
      check(r_fault && r_phys == 0, "R6 directory fault", r_phys, 32'h0);
      check(r_reqs == lat + 1, "R6 single read", r_reqs, lat + 1);
      run(32'h0040_5123, BASE, 1'b1);
      check(r_fault && r_phys == 0, "R7 table fault", r_phys, 32'h0);
      run(32'hDEAD_BEEF, BASE, 1'b0);
      check(r_phys == 32'hDEAD_BEEF && !r_fault, "R8 bypass value", r_phys, 32'hDEAD_BEEF);
      check(r_reqs == 0, "R8 no memory access", r_reqs, 0);
      check(phys_addr_o == 32'hDEAD_BEEF, "R10 hold after done", phys_addr_o, 32'hDEAD_BEEF);
    end

    // R9: second strobe during a slow directory read is ignored
    lat = 4;
    @(negedge clk_i);
    lin_addr_i = 32'h0040_3ABC; dir_base_i = BASE; paging_en_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    lin_addr_i = 32'hFFFF_FFFF; dir_base_i = 32'h0005_0000; paging_en_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 200 && !done_o; i++) @(negedge clk_i);
    check(phys_addr_o == 32'h1234_5ABC && !fault_o, "R9 strobe ignored", phys_addr_o, 32'h1234_5ABC);
    // strobe in the completion cycle is also ignored
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(!done_o && !mem_req_o, "R9 strobe in done cycle", {30'b0, done_o, mem_req_o}, 32'h0);
    repeat (4) @(negedge clk_i);

    finish_run();
  end
endmodule